// File: doc/BRIEF.md
# Card Presence Debounce and Interrupt Controller

This block sits between the card-detect contacts of a smart card connector and the host controller. It accepts two presence contacts of opposite polarity, so that either a normally-open or a normally-closed connector can be wired. A card counts as present when either contact reports it. Insertion is accepted only after the contact has stayed stable for a debounce window of about 8 ms. Removal is accepted at once, and the block then asks the activation sequencer to power the card down.

A single active-low interrupt line carries the status to the host. Outside a card session, the line shows whether a debounced card is present. During a session, it also drops on any fault flag. That fault indication stays latched until the session command is withdrawn and the sequencer reports that deactivation has finished.

A supply undervoltage flag overrides everything else. The line drops at once, and the block stays in a power-on hold for a fixed pulse length after the supply recovers. Debouncing then starts again from zero. The same hold pulse is applied after the synchronous reset.

All asynchronous inputs pass through a synchronizer of `SYNC_STAGES` flops (2 by default). The interrupt output and the removal request are registered. The latencies below assume the default synchronizer depth and count rising clock edges after the edge at which an input change is first sampled.

Top module: `card_presence_irq`

## Requirements
- R1: The raw card state is present when `det_open_n_i` is 0 or `det_closed_i` is 1. With `det_open_n_i`=1 and `det_closed_i`=0 the card is absent. A change on one contact while the other still reports present leaves the interrupt unchanged.
- R2: After the raw state turns present, with no hold and no fault, `irq_n_o` is 0 up to edge `DEBOUNCE_CYCLES`+2 and becomes 1 at edge `DEBOUNCE_CYCLES`+3.
- R3: If the raw state returns to absent during the debounce window, the window restarts. The interrupt rises `DEBOUNCE_CYCLES`+3 edges after the last return to present.
- R4: When a debounced card is removed, `irq_n_o` falls and `remove_req_o` is 1 for exactly one cycle, both at edge 3. This applies both inside and outside a session.
- R5: While `session_i`=0, `irq_n_o` equals the debounced presence, and the fault flags have no effect on it.
- R6: While `uv_i` is 1, `irq_n_o` is 0 from edge 3 on. After `uv_i` returns to 0, the hold lasts `POR_CYCLES` further cycles and debouncing restarts. With a card present, `irq_n_o` rises at edge `POR_CYCLES`+`DEBOUNCE_CYCLES`+3 after the release.
- R7: During `rst`, `irq_n_o` and `remove_req_o` are 0. After `rst` is released with a card present, `irq_n_o` rises at edge `POR_CYCLES`+`DEBOUNCE_CYCLES`+1.
- R8: While `session_i`=1, any bit of `fault_i` that becomes 1 drives `irq_n_o` to 0 at edge 3. The line stays 0 after the fault flag clears.
- R9: The latched fault is cleared only when `session_i`=0 and `seq_idle_i`=1 at the same time. `irq_n_o` then returns to the presence state at edge 2 after that condition is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset; starts a hold pulse |
| det_open_n_i | input | 1 | Presence contact, low when a card is present (normally-open connector) |
| det_closed_i | input | 1 | Presence contact, high when a card is present (normally-closed connector) |
| uv_i | input | 1 | Supply undervoltage flag, active high, asynchronous |
| fault_i | input | NFAULT | Fault flags from the protection circuits, active high, asynchronous |
| session_i | input | 1 | Host command that a card session is open, synchronous |
| seq_idle_i | input | 1 | Sequencer reports that the card is fully deactivated, synchronous |
| irq_n_o | output | 1 | Active-low interrupt to the host |
| remove_req_o | output | 1 | One-cycle request to the sequencer to deactivate after removal |

## Verification
The assertions assume that `session_i` and `seq_idle_i` come from logic in the same clock domain. The stimulus therefore changes them only at the falling clock edge. The assertions also assume that `POR_CYCLES` and `DEBOUNCE_CYCLES` are at least 2, so that a hold or a debounce window always lasts beyond one cycle. The bench overrides both parameters with short values in that range. Every pin change is held for at least one full cycle, so that each change passes through the synchronizer. The bench checks latencies only for changes that are separated by more cycles than the synchronizer depth.

// File: rtl/cp_pkg.sv
package cp_pkg;
  // Index of each asynchronous flag inside the shared synchronizer vector.
  localparam int unsigned IDX_DET_OPEN_N = 0;
  localparam int unsigned IDX_DET_CLOSED = 1;
  localparam int unsigned IDX_UV         = 2;
  localparam int unsigned IDX_FAULT_LO   = 3;

  // Either contact reporting a card is enough.
  function automatic logic card_seen(input logic open_n, input logic closed);
    return (!open_n) | closed;
  endfunction
endpackage

// File: rtl/cp_sync.sv
module cp_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cp_por_hold.sv
module cp_por_hold #(
  parameter int unsigned POR_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= LOAD;
    else if (uv_i)        cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = uv_i | (cnt_q != '0);

  // R6: once the supply recovers, the hold lasts beyond the release cycle
  assert_hold_after_recovery_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(uv_i) |-> hold_o);
endmodule

// File: rtl/cp_presence_filter.sv
module cp_presence_filter #(
  parameter int unsigned DEBOUNCE_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic raw_i,
  output logic present_o,
  output logic remove_o
);
  localparam int unsigned CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          present_q;
  logic          remove_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q     <= '0;
      present_q <= 1'b0;
    end else if (!raw_i) begin
      // Removal, or a bounce inside the window: start over.
      cnt_q     <= '0;
      present_q <= 1'b0;
    end else if (!present_q) begin
      if (cnt_q == LAST) present_q <= 1'b1;
      else               cnt_q     <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) remove_q <= 1'b0;
    else     remove_q <= present_q & ~raw_i & ~hold_i;
  end

  assign present_o = present_q;
  assign remove_o  = remove_q;

  // R4: an absent sample always clears the debounced state at the next edge
  assert_absent_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !raw_i |=> !present_q);
  // R2: presence is accepted only after the contact was seen present
  assert_rise_needs_raw_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(present_q) |-> $past(raw_i));
  // R4: the removal request is a single-cycle pulse
  assert_remove_single_R4: assert property (@(posedge clk) disable iff (rst)
    remove_q |=> !remove_q);
  // R4: a request goes out only for a card that has just been dropped
  assert_remove_after_drop_R4: assert property (@(posedge clk) disable iff (rst)
    remove_q |-> !present_q);
endmodule

// File: rtl/cp_irq_ctrl.sv
module cp_irq_ctrl #(
  parameter int unsigned NFAULT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              raw_i,
  input  logic              present_i,
  input  logic [NFAULT-1:0] fault_i,
  input  logic              session_i,
  input  logic              seq_idle_i,
  output logic              irq_n_o
);
  logic fault_now;
  logic latched_q;
  logic irq_n_q;

  assign fault_now = session_i & (|fault_i);

  always_ff @(posedge clk) begin
    if (rst || hold_i)               latched_q <= 1'b0;
    else if (fault_now)              latched_q <= 1'b1;
    else if (!session_i && seq_idle_i) latched_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i)               irq_n_q <= 1'b0;
    else if (!(raw_i && present_i))  irq_n_q <= 1'b0;
    else if (latched_q || fault_now) irq_n_q <= 1'b0;
    else                             irq_n_q <= 1'b1;
  end

  assign irq_n_o = irq_n_q;

  // R8: a latched fault keeps the interrupt asserted
  assert_fault_holds_irq_R8: assert property (@(posedge clk) disable iff (rst)
    latched_q |=> !irq_n_q);
  // R8: a session fault asserts the interrupt and latches it
  assert_fault_latches_R8: assert property (@(posedge clk) disable iff (rst)
    (fault_now && !hold_i) |=> (latched_q && !irq_n_q));
  // R9: the latch is never cleared while the session command is still active
  assert_no_clear_in_session_R9: assert property (@(posedge clk) disable iff (rst)
    (latched_q && session_i && !hold_i) |=> latched_q);
  // R6: a hold forces the interrupt low and wipes the latch
  assert_hold_forces_low_R6: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (!irq_n_q && !latched_q));
  // R4: an absent card never leaves the interrupt released
  assert_absent_irq_low_R4: assert property (@(posedge clk) disable iff (rst)
    !raw_i |=> !irq_n_q);
endmodule

// File: rtl/card_presence_irq.sv
module card_presence_irq #(
  parameter int unsigned DEBOUNCE_CYCLES = 8000,
  parameter int unsigned POR_CYCLES      = 8000,
  parameter int unsigned NFAULT          = 3,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_open_n_i,
  input  logic              det_closed_i,
  input  logic              uv_i,
  input  logic [NFAULT-1:0] fault_i,
  input  logic              session_i,
  input  logic              seq_idle_i,
  output logic              irq_n_o,
  output logic              remove_req_o
);
  import cp_pkg::*;

  localparam int unsigned SW = NFAULT + 3;
  // The open-connector contact idles high, so it resets to "absent".
  localparam logic [SW-1:0] SYNC_RST = SW'(1) << IDX_DET_OPEN_N;

  logic [SW-1:0]     async_vec;
  logic [SW-1:0]     sync_vec;
  logic              raw_present;
  logic              hold;
  logic              present;
  logic [NFAULT-1:0] fault_s;

  assign async_vec[IDX_DET_OPEN_N] = det_open_n_i;
  assign async_vec[IDX_DET_CLOSED] = det_closed_i;
  assign async_vec[IDX_UV]         = uv_i;
  assign async_vec[SW-1:IDX_FAULT_LO] = fault_i;

  cp_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst(rst), .d_i(async_vec), .q_o(sync_vec)
  );

  assign raw_present = card_seen(sync_vec[IDX_DET_OPEN_N], sync_vec[IDX_DET_CLOSED]);
  assign fault_s     = sync_vec[SW-1:IDX_FAULT_LO];

  cp_por_hold #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .rst(rst), .uv_i(sync_vec[IDX_UV]), .hold_o(hold)
  );

  cp_presence_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filt (
    .clk(clk), .rst(rst), .hold_i(hold), .raw_i(raw_present),
    .present_o(present), .remove_o(remove_req_o)
  );

  cp_irq_ctrl #(.NFAULT(NFAULT)) u_irq (
    .clk(clk), .rst(rst), .hold_i(hold), .raw_i(raw_present),
    .present_i(present), .fault_i(fault_s), .session_i(session_i),
    .seq_idle_i(seq_idle_i), .irq_n_o(irq_n_o)
  );

  // R6: an undervoltage sample forces the interrupt low at the next edge
  assert_uv_irq_low_R6: assert property (@(posedge clk) disable iff (rst)
    sync_vec[IDX_UV] |=> !irq_n_o);
  // R2: the interrupt is released only for a debounced card
  assert_release_needs_card_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n_o) |-> $past(present));
  // R4: no removal request while the interrupt is released
  assert_request_irq_low_R4: assert property (@(posedge clk) disable iff (rst)
    remove_req_o |-> !irq_n_o);
endmodule

// File: tb/card_presence_irq_test.sv
module card_presence_irq_test;
  localparam int unsigned D  = 40;
  localparam int unsigned P  = 30;
  localparam int unsigned NF = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          det_open_n = 1'b1;
  logic          det_closed = 1'b1;
  logic          uv = 1'b0;
  logic [NF-1:0] fault = '0;
  logic          session = 1'b0;
  logic          seq_idle = 1'b1;
  logic          irq_n;
  logic          remove_req;

  card_presence_irq #(
    .DEBOUNCE_CYCLES(D), .POR_CYCLES(P), .NFAULT(NF), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst(rst), .det_open_n_i(det_open_n), .det_closed_i(det_closed),
    .uv_i(uv), .fault_i(fault), .session_i(session), .seq_idle_i(seq_idle),
    .irq_n_o(irq_n), .remove_req_o(remove_req)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    logic  irq;
    logic  rem;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Expect irq_n and remove_req after the d-th rising edge from now.
  task automatic expect_at(input int d, input logic irq, input logic rem, input string req);
    exp_t e;
    int   pos;
    e.cyc = cyc + d; e.irq = irq; e.rem = rem; e.req = req;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare items whose cycle has come, away from the rising edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (irq_n !== e.irq || remove_req !== e.rem) begin
        n_bad++;
        $display("FAIL %s cyc=%0d irq_n=%b rem=%b expected irq_n=%b rem=%b",
                 e.req, cyc, irq_n, remove_req, e.irq, e.rem);
      end
    end
  end

  initial begin
    // R7: reset state, card present on the closed-type contact
    step(2);
    expect_at(1, 1'b0, 1'b0, "R7");
    step(3);
    rst = 1'b0;
    expect_at(P + D, 1'b0, 1'b0, "R7");
    expect_at(P + D + 1, 1'b1, 1'b0, "R7");
    step(P + D + 3);

    // R1: both contacts active, then one released: still present
    det_open_n = 1'b0;
    expect_at(4, 1'b1, 1'b0, "R1");
    step(5);
    det_closed = 1'b0;
    expect_at(3, 1'b1, 1'b0, "R1");
    expect_at(5, 1'b1, 1'b0, "R1");
    step(6);

    // R4: removal outside a session
    det_open_n = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R4");
    expect_at(3, 1'b0, 1'b1, "R4");
    expect_at(4, 1'b0, 1'b0, "R4");
    step(6);

    // R2: insertion on the open-type contact
    det_open_n = 1'b0;
    expect_at(D + 2, 1'b0, 1'b0, "R2");
    expect_at(D + 3, 1'b1, 1'b0, "R2");
    step(D + 5);
    det_open_n = 1'b1;
    expect_at(3, 1'b0, 1'b1, "R4");
    step(6);

    // R3: bounce inside the window restarts it
    det_open_n = 1'b0;
    step(20);
    det_open_n = 1'b1;
    step(1);
    det_open_n = 1'b0;
    expect_at(22, 1'b0, 1'b0, "R3");
    expect_at(D + 2, 1'b0, 1'b0, "R3");
    expect_at(D + 3, 1'b1, 1'b0, "R3");
    step(D + 5);

    // R5: faults ignored outside a session
    fault = 3'b010;
    expect_at(3, 1'b1, 1'b0, "R5");
    expect_at(5, 1'b1, 1'b0, "R5");
    step(6);
    fault = '0;
    step(3);

    // R8: session fault latches
    session = 1'b1; seq_idle = 1'b0;
    expect_at(2, 1'b1, 1'b0, "R8");
    step(3);
    fault = 3'b001;
    expect_at(2, 1'b1, 1'b0, "R8");
    expect_at(3, 1'b0, 1'b0, "R8");
    step(4);
    fault = '0;
    expect_at(5, 1'b0, 1'b0, "R8");
    step(6);

    // R9: cleared only with session withdrawn and sequencer idle
    session = 1'b0;
    expect_at(3, 1'b0, 1'b0, "R9");
    step(4);
    seq_idle = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R9");
    expect_at(2, 1'b1, 1'b0, "R9");
    step(4);

    // R4: removal during a session
    session = 1'b1; seq_idle = 1'b0;
    step(3);
    det_open_n = 1'b1;
    expect_at(3, 1'b0, 1'b1, "R4");
    expect_at(4, 1'b0, 1'b0, "R4");
    step(5);
    session = 1'b0; seq_idle = 1'b1;

    // R6: undervoltage and recovery
    det_closed = 1'b1;
    expect_at(D + 3, 1'b1, 1'b0, "R6");
    step(D + 5);
    uv = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R6");
    expect_at(3, 1'b0, 1'b0, "R6");
    step(10);
    uv = 1'b0;
    expect_at(P + D + 2, 1'b0, 1'b0, "R6");
    expect_at(P + D + 3, 1'b1, 1'b0, "R6");
    step(P + D + 6);

    if (q.size() != 0) begin
      n_bad += q.size();
      $display("FAIL pending %0d expectations never compared", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule